// File: doc/BRIEF.md
# Read-After-Write Stall Unit

This block guards a four-stage in-order pipeline against a read-after-write conflict. The conflict arises between the instruction being decoded (the operand-fetch stage) and the instruction one step ahead of it in execute. For each operand the decoder supplies the register address and a flag. The flag says whether the operand really comes from the register file, or whether a substitute is used instead: the program counter for operand A, a constant for operand B. The block compares these addresses with the destination held by the execute stage. If a needed register is about to be written, the block raises a stall for exactly one cycle.

The block owns the control register that carries the decoded write, memory-write, branch-select and destination fields from operand fetch into execute. While a stall is raised, it loads that register with zeros. The result is a bubble that writes nothing and cannot branch. Because its destination is zero and its register write is off, the bubble cannot trigger the same conflict again. In the same cycle the hold outputs freeze the program counters and the fetch-to-decode instruction register. The stalled instruction is therefore presented again on the next cycle. The register file writes in the first half of a cycle and reads in the second half, so one bubble is always enough.

Top module: `hazard_stall_unit`

## Requirements
- R1: Conflict on operand A is flagged when the operand-A register select is 1, the execute-stage register write is 1, and the execute destination equals the operand-A address. With the select at 0 (program counter used), no conflict is flagged for that operand.
- R2: Conflict on operand B is flagged when the operand-B register select is 1, the execute-stage register write is 1, and the execute destination equals the operand-B address. With the select at 0 (constant used), no conflict is flagged for that operand.
- R3: `stall` is the OR of both operand conflicts. `holdPc`, `holdIr` and `killCtl` are each equal to `stall` in every cycle.
- R4: After a clock edge at which `stall` was 1, the execute-stage register write and memory write outputs are 0.
- R5: After a clock edge at which `stall` was 1, the execute-stage branch select output is 0.
- R6: After a clock edge at which `stall` was 1, the execute-stage destination output is 0.
- R7: After a clock edge at which `stall` was 0, the four execute-stage outputs equal the operand-fetch control inputs that were present before that edge.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, `stall` is 0 whatever the decode inputs are. The repeated instruction then enters execute on the following edge.
- R9: While `rstN` is low, and after it rises, the execute-stage outputs are all 0 and `stall` is 0 until a register-writing instruction has entered execute.
- R10: `stall` is a combinational function of the current inputs and execute-stage contents. A change of a read address within a cycle changes `stall` in that same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dofAddrA | input | REG_AW | Operand-A register address in operand fetch |
| dofAddrB | input | REG_AW | Operand-B register address in operand fetch |
| dofSelRegA | input | 1 | 1 when operand A is read from the register file |
| dofSelRegB | input | 1 | 1 when operand B is read from the register file |
| dofDest | input | REG_AW | Destination address decoded in operand fetch |
| dofRegWr | input | 1 | Register write decoded in operand fetch |
| dofMemWr | input | 1 | Memory write decoded in operand fetch |
| dofBrSel | input | BR_W | Branch select decoded in operand fetch |
| stall | output | 1 | Conflict detected this cycle |
| holdPc | output | 1 | Hold all program-counter registers |
| holdIr | output | 1 | Hold the fetch-to-decode instruction register |
| killCtl | output | 1 | Zero the controls entering execute |
| exDest | output | REG_AW | Destination address in execute |
| exRegWr | output | 1 | Register write in execute |
| exMemWr | output | 1 | Memory write in execute |
| exBrSel | output | BR_W | Branch select in execute |

## Verification
The hardest situation to reach from the ports is the repeated instruction: a consumer held in decode whose producer has just been replaced by a bubble. It is the only case that shows whether the zeroed destination and write enable break the loop. The stimulus first loads a producer into execute through the normal decode inputs. It then applies a dependent consumer and leaves it unchanged across the stall edge. The stall must drop in the next cycle, and the same controls must then appear in execute one edge later. Matches on register 0 and register 31 are included, as are the pairs where a select points away from the register file.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef struct packed {
    logic stall;
    logic holdPc;
    logic holdIr;
    logic kill;
  } stallStrobes_t;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] dofAddrA,
  input  logic [REG_AW-1:0] dofAddrB,
  input  logic              dofSelRegA,
  input  logic              dofSelRegB,
  input  logic [REG_AW-1:0] exDest,
  input  logic              exRegWr,
  output stallStrobes_t     strobes
);
  logic [REG_AW-1:0] srcAddr [NUM_SRC];
  logic [NUM_SRC-1:0] srcUsesReg;
  logic [NUM_SRC-1:0] srcConflict;

  assign srcAddr[0]    = dofAddrA;
  assign srcAddr[1]    = dofAddrB;
  assign srcUsesReg[0] = dofSelRegA;
  assign srcUsesReg[1] = dofSelRegB;

  // one comparator per read port
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcConflict[i] = srcUsesReg[i] && exRegWr && (exDest == srcAddr[i]);
  end

  logic anyConflict;
  assign anyConflict = |srcConflict;

  always_comb begin
    strobes.stall  = anyConflict;
    strobes.holdPc = anyConflict;
    strobes.holdIr = anyConflict;
    strobes.kill   = anyConflict;
  end
endmodule

// File: rtl/hazard_dpath.sv
module hazard_dpath
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int BR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  stallStrobes_t     strobes,
  input  logic [REG_AW-1:0] dofDest,
  input  logic              dofRegWr,
  input  logic              dofMemWr,
  input  logic [BR_W-1:0]   dofBrSel,
  output logic [REG_AW-1:0] exDest,
  output logic              exRegWr,
  output logic              exMemWr,
  output logic [BR_W-1:0]   exBrSel
);
  logic [REG_AW-1:0] nxtDest;
  logic              nxtRegWr;
  logic              nxtMemWr;
  logic [BR_W-1:0]   nxtBrSel;

  // bubble: every control heading into execute becomes zero
  always_comb begin
    if (strobes.kill) begin
      nxtDest  = '0;
      nxtRegWr = 1'b0;
      nxtMemWr = 1'b0;
      nxtBrSel = '0;
    end else begin
      nxtDest  = dofDest;
      nxtRegWr = dofRegWr;
      nxtMemWr = dofMemWr;
      nxtBrSel = dofBrSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exDest  <= '0;
      exRegWr <= 1'b0;
      exMemWr <= 1'b0;
      exBrSel <= '0;
    end else begin
      exDest  <= nxtDest;
      exRegWr <= nxtRegWr;
      exMemWr <= nxtMemWr;
      exBrSel <= nxtBrSel;
    end
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int BR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] dofAddrA,
  input  logic [REG_AW-1:0] dofAddrB,
  input  logic              dofSelRegA,
  input  logic              dofSelRegB,
  input  logic [REG_AW-1:0] dofDest,
  input  logic              dofRegWr,
  input  logic              dofMemWr,
  input  logic [BR_W-1:0]   dofBrSel,
  output logic              stall,
  output logic              holdPc,
  output logic              holdIr,
  output logic              killCtl,
  output logic [REG_AW-1:0] exDest,
  output logic              exRegWr,
  output logic              exMemWr,
  output logic [BR_W-1:0]   exBrSel
);
  stallStrobes_t strobes;

  hazard_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .dofAddrA   (dofAddrA),
    .dofAddrB   (dofAddrB),
    .dofSelRegA (dofSelRegA),
    .dofSelRegB (dofSelRegB),
    .exDest     (exDest),
    .exRegWr    (exRegWr),
    .strobes    (strobes)
  );

  hazard_dpath #(.REG_AW(REG_AW), .BR_W(BR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dofDest  (dofDest),
    .dofRegWr (dofRegWr),
    .dofMemWr (dofMemWr),
    .dofBrSel (dofBrSel),
    .exDest   (exDest),
    .exRegWr  (exRegWr),
    .exMemWr  (exMemWr),
    .exBrSel  (exBrSel)
  );

  assign stall   = strobes.stall;
  assign holdPc  = strobes.holdPc;
  assign holdIr  = strobes.holdIr;
  assign killCtl = strobes.kill;
endmodule

// File: rtl/hazard_stall_chk.sv
module hazard_stall_chk #(
  parameter int REG_AW = 5,
  parameter int BR_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] dofAddrA,
  input logic [REG_AW-1:0] dofAddrB,
  input logic              dofSelRegA,
  input logic              dofSelRegB,
  input logic [REG_AW-1:0] dofDest,
  input logic              dofRegWr,
  input logic              dofMemWr,
  input logic [BR_W-1:0]   dofBrSel,
  input logic              stall,
  input logic              holdPc,
  input logic              holdIr,
  input logic              killCtl,
  input logic [REG_AW-1:0] exDest,
  input logic              exRegWr,
  input logic              exMemWr,
  input logic [BR_W-1:0]   exBrSel
);
  // R1
  opa_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dofSelRegA && exRegWr && exDest == dofAddrA) |-> stall);

  // R2
  opb_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dofSelRegB && exRegWr && exDest == dofAddrB) |-> stall);

  // R3
  hold_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdPc == stall) && (holdIr == stall) && (killCtl == stall));

  // R4
  bubble_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!exRegWr && !exMemWr));

  // R5
  bubble_nobranch_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (exBrSel == '0));

  // R6
  bubble_nodest_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (exDest == '0));

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> (exDest == $past(dofDest) && exRegWr == $past(dofRegWr) &&
                exMemWr == $past(dofMemWr) && exBrSel == $past(dofBrSel)));

  // R8
  single_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  // R9
  no_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exRegWr |-> !stall);
endmodule

bind hazard_stall_unit hazard_stall_chk #(.REG_AW(REG_AW), .BR_W(BR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dofAddrA   (dofAddrA),
  .dofAddrB   (dofAddrB),
  .dofSelRegA (dofSelRegA),
  .dofSelRegB (dofSelRegB),
  .dofDest    (dofDest),
  .dofRegWr   (dofRegWr),
  .dofMemWr   (dofMemWr),
  .dofBrSel   (dofBrSel),
  .stall      (stall),
  .holdPc     (holdPc),
  .holdIr     (holdIr),
  .killCtl    (killCtl),
  .exDest     (exDest),
  .exRegWr    (exRegWr),
  .exMemWr    (exMemWr),
  .exBrSel    (exBrSel)
);

// File: tb/hazard_stall_unit_test.sv
module hazard_stall_unit_test;
  localparam int AW = 5;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] dofAddrA = '0, dofAddrB = '0, dofDest = '0;
  logic dofSelRegA = 1'b0, dofSelRegB = 1'b0, dofRegWr = 1'b0, dofMemWr = 1'b0;
  logic [BW-1:0] dofBrSel = '0;
  logic stall, holdPc, holdIr, killCtl, exRegWr, exMemWr;
  logic [AW-1:0] exDest;
  logic [BW-1:0] exBrSel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hazard_stall_unit #(.REG_AW(AW), .BR_W(BW)) uut (
    .clk(clk), .rstN(rstN),
    .dofAddrA(dofAddrA), .dofAddrB(dofAddrB),
    .dofSelRegA(dofSelRegA), .dofSelRegB(dofSelRegB),
    .dofDest(dofDest), .dofRegWr(dofRegWr), .dofMemWr(dofMemWr), .dofBrSel(dofBrSel),
    .stall(stall), .holdPc(holdPc), .holdIr(holdIr), .killCtl(killCtl),
    .exDest(exDest), .exRegWr(exRegWr), .exMemWr(exMemWr), .exBrSel(exBrSel)
  );

  typedef struct packed {
    logic [AW-1:0] pDest;
    logic          pWr;
    logic [AW-1:0] aa;
    logic [AW-1:0] ba;
    logic          sa;
    logic          sb;
    logic [AW-1:0] cDest;
    logic          cWr;
    logic          cMem;
    logic [BW-1:0] cBr;
    logic          exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd1,  1'b1, 5'd1,  5'd9,  1'b1, 1'b0, 5'd2,  1'b1, 1'b0, 2'd0, 1'b1},
    '{5'd1,  1'b1, 5'd9,  5'd1,  1'b0, 1'b1, 5'd3,  1'b1, 1'b1, 2'd3, 1'b1},
    '{5'd1,  1'b1, 5'd1,  5'd9,  1'b0, 1'b1, 5'd4,  1'b0, 1'b1, 2'd1, 1'b0},
    '{5'd1,  1'b1, 5'd9,  5'd1,  1'b1, 1'b0, 5'd5,  1'b1, 1'b0, 2'd2, 1'b0},
    '{5'd1,  1'b0, 5'd1,  5'd1,  1'b1, 1'b1, 5'd6,  1'b1, 1'b1, 2'd3, 1'b0},
    '{5'd3,  1'b1, 5'd2,  5'd4,  1'b1, 1'b1, 5'd7,  1'b1, 1'b0, 2'd1, 1'b0},
    '{5'd7,  1'b1, 5'd7,  5'd7,  1'b1, 1'b1, 5'd8,  1'b1, 1'b1, 2'd2, 1'b1},
    '{5'd0,  1'b1, 5'd0,  5'd12, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 2'd3, 1'b1},
    '{5'd31, 1'b1, 5'd30, 5'd31, 1'b1, 1'b1, 5'd29, 1'b0, 1'b1, 2'd3, 1'b1},
    '{5'd5,  1'b1, 5'd6,  5'd5,  1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_then_settle();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic sa,
                       input logic sb, input logic [AW-1:0] d, input logic w,
                       input logic m, input logic [BW-1:0] br);
    dofAddrA = a; dofAddrB = b; dofSelRegA = sa; dofSelRegB = sb;
    dofDest = d; dofRegWr = w; dofMemWr = m; dofBrSel = br;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset with a writer sitting on the decode inputs
    drive(5'd0, 5'd0, 1'b1, 1'b1, 5'd4, 1'b1, 1'b1, 2'd3);
    repeat (3) @(posedge clk);
    #2;
    check("R9 exRegWr in reset", int'(exRegWr), 0);
    check("R9 exDest in reset", int'(exDest), 0);
    check("R9 exMemWr/exBrSel in reset", int'({exMemWr, exBrSel}), 0);
    check("R9 stall in reset", int'(stall), 0);
    drive(5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9 stall after release", int'(stall), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      edge_then_settle();
      drive(5'd0, 5'd0, 1'b0, 1'b0, v.pDest, v.pWr, 1'b0, 2'd0);
      edge_then_settle();
      drive(v.aa, v.ba, v.sa, v.sb, v.cDest, v.cWr, v.cMem, v.cBr);
      #1;
      check($sformatf("R1 R2 stall vec%0d", i), int'(stall), int'(v.exp));
      check($sformatf("R3 holds vec%0d", i), int'({holdPc, holdIr, killCtl}),
            v.exp ? 7 : 0);
      edge_then_settle();
      if (v.exp) begin
        check($sformatf("R4 bubble writes vec%0d", i), int'({exRegWr, exMemWr}), 0);
        check($sformatf("R5 bubble branch vec%0d", i), int'(exBrSel), 0);
        check($sformatf("R6 bubble dest vec%0d", i), int'(exDest), 0);
        check($sformatf("R8 stall cleared vec%0d", i), int'(stall), 0);
        edge_then_settle();
        check($sformatf("R8 repeat enters vec%0d", i),
              int'({exDest, exRegWr, exMemWr, exBrSel}),
              int'({v.cDest, v.cWr, v.cMem, v.cBr}));
      end else begin
        check($sformatf("R7 pass vec%0d", i),
              int'({exDest, exRegWr, exMemWr, exBrSel}),
              int'({v.cDest, v.cWr, v.cMem, v.cBr}));
      end
    end

    // R10: stall follows the read address inside a single cycle
    edge_then_settle();
    drive(5'd0, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 1'b0, 2'd0);
    edge_then_settle();
    drive(5'd8, 5'd0, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 2'd0);
    #1 check("R10 no match", int'(stall), 0);
    dofAddrA = 5'd9;
    #1 check("R10 match same cycle", int'(stall), 1);
    dofAddrA = 5'd8;
    #1 check("R10 match removed", int'(stall), 0);

    // R9: reset in the middle of a run clears a loaded writer
    edge_then_settle();
    drive(5'd0, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 1'b1, 2'd2);
    edge_then_settle();
    check("R9 writer loaded", int'(exDest), 12);
    drive(5'd12, 5'd0, 1'b1, 1'b0, 5'd1, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R9 cleared by reset", int'({exDest, exRegWr, exMemWr, exBrSel}), 0);
    check("R9 no stall after clear", int'(stall), 0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule